// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode with register read, execute, memory, write-back) keeps correct data flowing without software help. It is purely combinational. It compares the source register numbers of the instructions in decode and in execute with the destination numbers, write flags and load flags held in the later pipeline registers. From this it produces operand bypass selects for the execute stage, a separate bypass select for the branch operand read in decode, a single stall signal, and a branch-taken signal.

When `stall` is high, the surrounding pipeline holds the program counter and the fetch/decode register, and it loads a no-op into the decode/execute register. Branches are resolved in decode. A branch tests one register for zero or non-zero. The instruction after a branch is its delay slot and always executes, so no flush is needed. When `br_taken` is high, the fetch that follows the delay slot uses the branch target. Reads occur only in decode and writes only in write-back, so write-after-read and write-after-write conflicts cannot occur. Only source reads are compared.

Top module: `hazard_ctl`

## Requirements
- R1: A destination of register 0 never produces a nonzero bypass select and never raises `stall`, whatever the write and load flags say.
- R2: An execute-stage source that matches a writing, nonzero destination in the execute/memory register gets select 2'b10, and this match alone does not stall.
- R3: An execute-stage source that matches only a writing, nonzero destination in the memory/write-back register gets select 2'b01.
- R4: When both later registers write the needed register, select 2'b10 (the younger result) wins over 2'b01.
- R5: With no match, or with the write flag low, the select is 2'b00 (register file). With all write flags low, `stall` is 0.
- R6: A load in execute whose nonzero destination equals a decode source with its use flag set raises `stall` for exactly that condition. A matching source whose use flag is low does not stall.
- R7: A non-load instruction in execute never stalls a non-branch instruction in decode.
- R8: A branch in decode stalls when its tested register is written by the instruction in execute (load or not), or by a load in the execute/memory register.
- R9: The decode branch operand select `id_fwd` uses the same encoding and priority as R2 to R4, against the execute/memory and memory/write-back destinations.
- R10: `br_taken` is 1 only when `id_is_branch` is 1, `stall` is 0, and the selected operand is zero (for `id_br_nz`=0) or non-zero (for `id_br_nz`=1). Otherwise it is 0.
- R11: No select output ever carries the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | RW | Decode first source register (the tested register for branches) |
| id_rs2 | input | RW | Decode second source register |
| id_use_rs1 | input | 1 | Decode instruction reads id_rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads id_rs2 |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_nz | input | 1 | Branch sense: 0 taken on zero, 1 taken on non-zero |
| id_rf_val | input | XLEN | Register file value read for id_rs1 |
| ex_rs1 | input | RW | Execute stage first source |
| ex_rs2 | input | RW | Execute stage second source |
| ex_rd | input | RW | Execute stage destination |
| ex_we | input | 1 | Execute stage writes ex_rd |
| ex_is_load | input | 1 | Execute stage holds a load |
| em_rd | input | RW | Execute/memory register destination |
| em_we | input | 1 | Execute/memory register writes em_rd |
| em_is_load | input | 1 | Execute/memory register holds a load |
| em_result | input | XLEN | ALU result held in execute/memory register |
| mw_rd | input | RW | Memory/write-back register destination |
| mw_we | input | 1 | Memory/write-back register writes mw_rd |
| mw_result | input | XLEN | Write-back value held in memory/write-back register |
| fwd_a | output | 2 | Execute first operand select |
| fwd_b | output | 2 | Execute second operand select |
| id_fwd | output | 2 | Decode branch operand select |
| stall | output | 1 | Hold front end and insert bubble |
| br_taken | output | 1 | Redirect fetch to target after the delay slot |

## Verification
A branch waiting on a producer and a load-use conflict can both occur in the same cycle. A branch stall also has to suppress the branch decision that the bypass logic would otherwise make. The branch sweep places a producer in execute, in the execute/memory register and in the memory/write-back register at the same time, and varies which of the three candidate values is zero. The bench then judges `stall`, `id_fwd` and `br_taken` together against its own priority model. The stall sweep crosses load flags, use flags and the branch flag, so that load-use and branch waits coincide.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef logic [1:0] fwd_sel_t;
  localparam fwd_sel_t FWD_RF  = 2'b00;
  localparam fwd_sel_t FWD_WB  = 2'b01;
  localparam fwd_sel_t FWD_MEM = 2'b10;
endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
  import hz_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] rs,
  input  logic [RW-1:0] em_rd,
  input  logic          em_we,
  input  logic [RW-1:0] mw_rd,
  input  logic          mw_we,
  output fwd_sel_t      sel
);
  function automatic logic dest_hit(input logic [RW-1:0] rd,
                                    input logic we,
                                    input logic [RW-1:0] src);
    return we && (rd != '0) && (rd == src);
  endfunction

  logic em_hit;
  logic mw_hit;

  assign em_hit = dest_hit(em_rd, em_we, rs);
  assign mw_hit = dest_hit(mw_rd, mw_we, rs);

  always_comb begin
    if (em_hit)      sel = FWD_MEM;
    else if (mw_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  always_comb begin
    if (!$isunknown({rs, em_rd, em_we, mw_rd, mw_we})) begin
      a_r1_zero_reg_not_bypassed: assert (rs != '0 || sel == FWD_RF)
        else $error("register 0 bypassed");
      a_r11_legal_code: assert (sel != 2'b11)
        else $error("illegal select code");
      a_r4_younger_first: assert (!(em_hit && mw_hit) || sel == FWD_MEM)
        else $error("older result chosen");
    end
  end
endmodule

// File: rtl/hz_stall_det.sv
module hz_stall_det #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic          id_is_branch,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_is_load,
  input  logic [RW-1:0] em_rd,
  input  logic          em_we,
  input  logic          em_is_load,
  output logic          stall
);
  function automatic logic reads_dest(input logic [RW-1:0] rd,
                                      input logic we,
                                      input logic used,
                                      input logic [RW-1:0] src);
    return used && we && (rd != '0) && (rd == src);
  endfunction

  logic ex_hit1, ex_hit2, em_hit_br;
  logic load_use;
  logic br_wait;

  assign ex_hit1   = reads_dest(ex_rd, ex_we, id_use_rs1, id_rs1);
  assign ex_hit2   = reads_dest(ex_rd, ex_we, id_use_rs2, id_rs2);
  assign em_hit_br = reads_dest(em_rd, em_we, 1'b1, id_rs1);

  assign load_use = ex_is_load && (ex_hit1 || ex_hit2);
  assign br_wait  = id_is_branch && (ex_hit1 || (em_is_load && em_hit_br));
  assign stall    = load_use || br_wait;

  always_comb begin
    if (!$isunknown({id_rs1, id_rs2, id_use_rs1, id_use_rs2, id_is_branch,
                     ex_rd, ex_we, ex_is_load, em_rd, em_we, em_is_load})) begin
      a_r1_no_stall_on_zero: assert (!stall || ex_rd != '0 || em_rd != '0)
        else $error("stall on register 0");
      a_r5_idle_no_stall: assert (ex_we || em_we || !stall)
        else $error("stall without writer");
      a_r7_alu_no_stall: assert (ex_is_load || id_is_branch || !stall)
        else $error("ALU producer stalled non-branch");
    end
  end
endmodule

// File: rtl/hz_branch_res.sv
module hz_branch_res
  import hz_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            is_branch,
  input  logic            on_nz,
  input  fwd_sel_t        sel,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] em_val,
  input  logic [XLEN-1:0] mw_val,
  input  logic            stall,
  output logic            taken
);
  function automatic logic cond_met(input logic [XLEN-1:0] v, input logic nz);
    return nz ? (v != '0) : (v == '0);
  endfunction

  logic [XLEN-1:0] opnd;

  always_comb begin
    unique case (sel)
      FWD_MEM: opnd = em_val;
      FWD_WB:  opnd = mw_val;
      default: opnd = rf_val;
    endcase
  end

  assign taken = is_branch && !stall && cond_met(opnd, on_nz);

  always_comb begin
    if (!$isunknown({is_branch, stall, sel})) begin
      a_r10_no_redirect_when_held: assert (!(stall && taken))
        else $error("redirect during stall");
      a_r10_only_branches: assert (is_branch || !taken)
        else $error("non-branch redirect");
    end
  end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hz_pkg::*;
#(
  parameter int RW   = 5,
  parameter int XLEN = 32
) (
  input  logic [RW-1:0]   id_rs1,
  input  logic [RW-1:0]   id_rs2,
  input  logic            id_use_rs1,
  input  logic            id_use_rs2,
  input  logic            id_is_branch,
  input  logic            id_br_nz,
  input  logic [XLEN-1:0] id_rf_val,
  input  logic [RW-1:0]   ex_rs1,
  input  logic [RW-1:0]   ex_rs2,
  input  logic [RW-1:0]   ex_rd,
  input  logic            ex_we,
  input  logic            ex_is_load,
  input  logic [RW-1:0]   em_rd,
  input  logic            em_we,
  input  logic            em_is_load,
  input  logic [XLEN-1:0] em_result,
  input  logic [RW-1:0]   mw_rd,
  input  logic            mw_we,
  input  logic [XLEN-1:0] mw_result,
  output logic [1:0]      fwd_a,
  output logic [1:0]      fwd_b,
  output logic [1:0]      id_fwd,
  output logic            stall,
  output logic            br_taken
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][RW-1:0] ex_src;
  fwd_sel_t [NSRC-1:0]     ex_sel;
  fwd_sel_t                br_sel;
  logic                    hold;

  assign ex_src = {ex_rs2, ex_rs1};

  for (genvar g = 0; g < NSRC; g++) begin : g_ex_opnd
    hz_operand_fwd #(.RW(RW)) u_fwd (
      .rs    (ex_src[g]),
      .em_rd (em_rd),
      .em_we (em_we),
      .mw_rd (mw_rd),
      .mw_we (mw_we),
      .sel   (ex_sel[g])
    );
  end

  hz_operand_fwd #(.RW(RW)) u_id_fwd (
    .rs    (id_rs1),
    .em_rd (em_rd),
    .em_we (em_we),
    .mw_rd (mw_rd),
    .mw_we (mw_we),
    .sel   (br_sel)
  );

  hz_stall_det #(.RW(RW)) u_stall (
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_use_rs1   (id_use_rs1),
    .id_use_rs2   (id_use_rs2),
    .id_is_branch (id_is_branch),
    .ex_rd        (ex_rd),
    .ex_we        (ex_we),
    .ex_is_load   (ex_is_load),
    .em_rd        (em_rd),
    .em_we        (em_we),
    .em_is_load   (em_is_load),
    .stall        (hold)
  );

  hz_branch_res #(.XLEN(XLEN)) u_br (
    .is_branch (id_is_branch),
    .on_nz     (id_br_nz),
    .sel       (br_sel),
    .rf_val    (id_rf_val),
    .em_val    (em_result),
    .mw_val    (mw_result),
    .stall     (hold),
    .taken     (br_taken)
  );

  assign fwd_a  = ex_sel[0];
  assign fwd_b  = ex_sel[1];
  assign id_fwd = br_sel;
  assign stall  = hold;

  always_comb begin
    if (!$isunknown({ex_rd, ex_we, ex_is_load, id_is_branch, id_use_rs1, id_rs1})) begin
      a_r8_branch_waits_on_execute: assert (!(id_is_branch && id_use_rs1 && ex_we &&
                                              ex_rd != '0 && ex_rd == id_rs1) || stall)
        else $error("branch did not wait for execute producer");
      a_r6_load_use_holds: assert (!(ex_is_load && ex_we && id_use_rs1 &&
                                     ex_rd != '0 && ex_rd == id_rs1) || stall)
        else $error("load-use not held");
    end
  end
endmodule

// File: tb/sim_hazard_ctl.sv
`timescale 1ns/1ps
module sim_hazard_ctl;
  localparam int RW = 3;
  localparam int XLEN = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, em_rd, mw_rd;
  logic id_use_rs1, id_use_rs2, id_is_branch, id_br_nz;
  logic ex_we, ex_is_load, em_we, em_is_load, mw_we;
  logic [XLEN-1:0] id_rf_val, em_result, mw_result;
  logic [1:0] fwd_a, fwd_b, id_fwd;
  logic stall, br_taken;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  hazard_ctl #(.RW(RW), .XLEN(XLEN)) u0 (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .id_is_branch(id_is_branch), .id_br_nz(id_br_nz), .id_rf_val(id_rf_val),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .em_rd(em_rd), .em_we(em_we), .em_is_load(em_is_load), .em_result(em_result),
    .mw_rd(mw_rd), .mw_we(mw_we), .mw_result(mw_result),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .id_fwd(id_fwd), .stall(stall), .br_taken(br_taken)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench model of a bypass select: ranks candidate sources, younger wins.
  function automatic int model_sel(int src, int e_rd, int e_we, int m_rd, int m_we);
    int rank = 0;
    if (src == 0) return 0;
    if (m_we == 1 && m_rd == src) rank = 1;
    if (e_we == 1 && e_rd == src) rank = 2;
    return rank;
  endfunction

  task automatic quiet();
    id_rs1 = 0; id_rs2 = 0; id_use_rs1 = 0; id_use_rs2 = 0; id_is_branch = 0;
    id_br_nz = 0; id_rf_val = 8'h11; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_we = 0;
    ex_is_load = 0; em_rd = 0; em_we = 0; em_is_load = 0; em_result = 8'h22;
    mw_rd = 0; mw_we = 0; mw_result = 8'h33;
  endtask

  initial begin
    quiet();
    id_rs1 = 3; id_rs2 = 5; ex_rs1 = 3; ex_rs2 = 6; ex_rd = 3; em_rd = 3; mw_rd = 3;
    @(negedge clk);
    chk("R5", "idle fwd_a", fwd_a, 0);
    chk("R5", "idle fwd_b", fwd_b, 0);
    chk("R5", "idle id_fwd", id_fwd, 0);
    chk("R5", "idle stall", stall, 0);
    chk("R10", "idle br_taken", br_taken, 0);

    // Sweep 1: execute-stage bypass over every source/destination pairing.
    quiet();
    for (int s = 0; s < 8; s++)
      for (int er = 0; er < 8; er++)
        for (int ew = 0; ew < 2; ew++)
          for (int mr = 0; mr < 8; mr++)
            for (int mwv = 0; mwv < 2; mwv++) begin
              int ea, eb, s2;
              string tg;
              s2 = s ^ 5;
              ex_rs1 = RW'(s); ex_rs2 = RW'(s2);
              em_rd = RW'(er); em_we = ew[0]; mw_rd = RW'(mr); mw_we = mwv[0];
              ea = model_sel(s, er, ew, mr, mwv);
              eb = model_sel(s2, er, ew, mr, mwv);
              if (s == 0) tg = "R1";
              else if (ea == 2 && mwv == 1 && mr == s) tg = "R4";
              else if (ea == 2) tg = "R2";
              else if (ea == 1) tg = "R3";
              else tg = "R5";
              #1;
              chk(tg, "fwd_a", fwd_a, ea);
              chk((s2 == 0) ? "R1" : "R2", "fwd_b", fwd_b, eb);
              chk("R11", "fwd_a code", (fwd_a == 2'b11) ? 1 : 0, 0);
              chk("R2", "no stall from bypass", stall, 0);
            end

    // Sweep 2: load-use and branch waits against the execute stage.
    quiet();
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int d = 0; d < 8; d++)
          for (int f = 0; f < 32; f++) begin
            int we, ld, u1, u2, br, h1, h2, exp_st;
            string tg;
            we = f & 1; ld = (f >> 1) & 1; u1 = (f >> 2) & 1; u2 = (f >> 3) & 1; br = (f >> 4) & 1;
            id_rs1 = RW'(a); id_rs2 = RW'(b); ex_rd = RW'(d);
            ex_we = we[0]; ex_is_load = ld[0]; id_use_rs1 = u1[0]; id_use_rs2 = u2[0];
            id_is_branch = br[0]; id_rf_val = 0; id_br_nz = 0;
            h1 = (u1 == 1 && we == 1 && d != 0 && a == d) ? 1 : 0;
            h2 = (u2 == 1 && we == 1 && d != 0 && b == d) ? 1 : 0;
            exp_st = ((ld == 1 && (h1 + h2) > 0) || (br == 1 && h1 == 1)) ? 1 : 0;
            if (d == 0) tg = "R1";
            else if (br == 1) tg = "R8";
            else if (ld == 1) tg = "R6";
            else tg = "R7";
            #1;
            chk(tg, "stall", stall, exp_st);
            chk("R10", "br_taken", br_taken, (br == 1 && exp_st == 0) ? 1 : 0);
          end

    // Sweep 3: branch in decode with producers in all later stages at once.
    quiet();
    id_is_branch = 1; id_use_rs1 = 1;
    for (int a = 0; a < 4; a++)
      for (int xr = 0; xr < 4; xr++)
        for (int er = 0; er < 4; er++)
          for (int mr = 0; mr < 4; mr++)
            for (int fl = 0; fl < 16; fl++)
              for (int pz = 0; pz < 16; pz++) begin
                int xw, ew, el, mwv, nz, xh, eh, exp_st, exp_sel, v, exp_tk;
                xw = fl & 1; ew = (fl >> 1) & 1; el = (fl >> 2) & 1; mwv = (fl >> 3) & 1;
                nz = (pz >> 3) & 1;
                id_rs1 = RW'(a); ex_rd = RW'(xr); ex_we = xw[0];
                em_rd = RW'(er); em_we = ew[0]; em_is_load = el[0];
                mw_rd = RW'(mr); mw_we = mwv[0]; id_br_nz = nz[0];
                id_rf_val = pz[0] ? 8'h00 : 8'h3C;
                em_result = pz[1] ? 8'h00 : 8'hA5;
                mw_result = pz[2] ? 8'h00 : 8'h01;
                xh = (xw == 1 && xr != 0 && xr == a) ? 1 : 0;
                eh = (ew == 1 && er != 0 && er == a) ? 1 : 0;
                exp_st = (xh == 1 || (eh == 1 && el == 1)) ? 1 : 0;
                exp_sel = model_sel(a, er, ew, mr, mwv);
                v = (exp_sel == 2) ? int'(em_result) : (exp_sel == 1) ? int'(mw_result) : int'(id_rf_val);
                exp_tk = (exp_st == 0 && ((nz == 1) ? (v != 0) : (v == 0))) ? 1 : 0;
                #1;
                chk((a == 0) ? "R1" : "R8", "branch stall", stall, exp_st);
                chk("R9", "id_fwd", id_fwd, exp_sel);
                chk("R10", "br_taken", br_taken, exp_tk);
              end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule